// File: doc/BRIEF.md
# Four-Stream Zero-Overhead Context Switch Controller

This block is the local control of a lightly programmable processing element whose single datapath is time-shared by four independent data streams. Every stream owns a private input queue, a private output queue and a private state register. Nothing is shared between streams except the arithmetic itself. In each cycle a round-robin arbiter picks one stream that can make progress. The datapath consumes one token from that stream's input queue and combines it with that stream's state. The result is written back as the new state and is also pushed into the same stream's output queue.

Each stream holds a separate state bank, and the arbiter selects a bank directly. A change of stream therefore costs no cycle: a different stream can be served in every consecutive cycle. A stream whose input queue is empty, or whose output queue is full, is blocked. Its bank enable stays low, so its state is frozen exactly, and the arbiter passes over it. When no stream can run, the datapath idles. The token transform is a placeholder running sum: each output token is the modular sum of all tokens the stream has consumed so far. Debug outputs show the stream being served and which streams are blocked.

Top module: `stream_ctx_switch`

## Requirements
- R1: While reset is asserted and after it is released with no traffic, every `in_ready` bit is 1, every `out_valid` bit is 0, `dbg_busy` is 0 and every `dbg_blocked` bit is 1.
- R2: Tokens of stream i leave only on output lane i, in the order they were accepted on input lane i. A token is never lost or duplicated. A head token that is not taken (`out_valid` high, `out_ready` low) stays unchanged.
- R3: Each output token of stream i equals the sum, modulo 2^DATA_W, of all tokens stream i has consumed up to and including that one. Each stream's state starts at 0 after reset.
- R4: The arbiter searches for a runnable stream starting at the stream after the one last served, wrapping from 3 to 0. The search skips non-runnable streams within the same cycle. After reset the search starts at stream 0.
- R5: In every cycle in which at least one stream is runnable, exactly one stream is served. A switch between streams inserts no idle cycle.
- R6: A stream is runnable exactly when its input queue holds at least one token and its output queue holds fewer than FIFO_DEPTH tokens, both judged on the occupancy at the start of the cycle. `dbg_blocked[i]` is the inverse of stream i being runnable.
- R7: When no stream is runnable, `dbg_busy` is 0, no input token is consumed and no output token is produced.
- R8: The state of a stream blocked for any number of cycles is unchanged when it resumes. Its next output continues its running sum as if no stall had happened.
- R9: `in_ready[i]` is 1 exactly when input queue i holds fewer than FIFO_DEPTH tokens. A push offered while `in_ready[i]` is 0 is ignored.
- R10: While `dbg_busy` is 1, `dbg_active` gives the index (0 to 3) of the stream served in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 4 | Per-stream push request into the input queue |
| in_data | input | 4*DATA_W | Per-stream input token, stream i in bits [i*DATA_W +: DATA_W] |
| in_ready | output | 4 | Per-stream input queue has space |
| out_valid | output | 4 | Per-stream output queue holds a token |
| out_data | output | 4*DATA_W | Per-stream head token of the output queue, same packing as in_data |
| out_ready | input | 4 | Per-stream pop of the output queue head |
| dbg_active | output | 2 | Index of the stream served this cycle |
| dbg_busy | output | 1 | A stream is served this cycle |
| dbg_blocked | output | 4 | Per-stream blocked flag |

## Verification
Two functions can meet in one cycle on the same stream. The arbiter can serve stream i, which pops its input queue and pushes its output queue, in the same cycle that the environment pushes a new token into that input queue and pops the head of that output queue. The bench provokes this with dense random traffic on all lanes, with phases that fill every output queue to the brim and phases that hold one output lane closed while the others flow. A behavioural queue model decides every cycle, from start-of-cycle occupancy alone, which stream must be served and what each lane must show. Every visible port is then compared against that model at the falling edge.

// File: rtl/csw_pkg.sv
// Shared constants and types of the four-stream context switch controller.
// Assumes the stream count is a power of two so that index wrap is modulo.
package csw_pkg;

    localparam int CSW_NUM_STREAMS = 4;
    localparam int CSW_IDX_W       = $clog2(CSW_NUM_STREAMS);

    // Arbiter decision for one cycle.
    typedef struct packed {
        logic                 busy;
        logic [CSW_IDX_W-1:0] idx;
    } csw_grant_t;

endpackage

// File: rtl/csw_fifo.sv
// Synchronous single-clock queue with first-word fall-through output.
// Assumes push is only honoured when not full and pop only when not empty;
// simultaneous push and pop are allowed at any occupancy.
module csw_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    // Qualify the requests against the current occupancy.
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Storage array, written at the tail pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    // Pointers and occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Status flags and head word.
    always_comb begin
        full  = (cnt == CNT_W'(DEPTH));
        empty = (cnt == '0);
        dout  = mem[rptr];
    end

endmodule

// File: rtl/csw_rr_sched.sv
// Round-robin arbiter over the runnable streams. It searches from the stream
// after the last one served and grants within the same cycle. Assumes the
// stream count comes from csw_pkg.
module csw_rr_sched
    import csw_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CSW_NUM_STREAMS-1:0] runnable,
    output csw_grant_t                 grant
);
    logic [CSW_IDX_W-1:0] last_q;

    // Rotating search for the first runnable stream after last_q.
    always_comb begin
        grant = '0;
        for (int k = 1; k <= CSW_NUM_STREAMS; k++) begin
            int cand;
            cand = (int'(last_q) + k) % CSW_NUM_STREAMS;
            if (!grant.busy && runnable[cand]) begin
                grant.busy = 1'b1;
                grant.idx  = CSW_IDX_W'(cand);
            end
        end
    end

    // Remember the last served stream; reset so stream 0 is searched first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= CSW_IDX_W'(CSW_NUM_STREAMS - 1);
        end else if (grant.busy) begin
            last_q <= grant.idx;
        end
    end

endmodule

// File: rtl/csw_state_bank.sv
// Private state register of one stream. The enable freezes it, which stands
// in for clock gating. Assumes en is only high in the cycle the stream is served.
module csw_state_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Load on enable, otherwise hold bit for bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/csw_token_unit.sv
// Shared datapath: a placeholder transform that adds the incoming token to
// the stream state. Purely combinational; assumes the caller registers the result.
module csw_token_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] tok,
    output logic [WIDTH-1:0] nxt
);
    // Modular running sum.
    always_comb begin
        nxt = acc + tok;
    end

endmodule

// File: rtl/stream_ctx_switch.sv
// Four-stream time-shared controller. Each stream has its own input queue,
// output queue and state bank. The arbiter serves one runnable stream per
// cycle with no switch overhead. Blocked streams have their bank enable held
// low. Assumes out_data is only meaningful while the matching out_valid is high.
module stream_ctx_switch
    import csw_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CSW_NUM_STREAMS-1:0]        in_valid,
    input  logic [CSW_NUM_STREAMS*DATA_W-1:0] in_data,
    output logic [CSW_NUM_STREAMS-1:0]        in_ready,
    output logic [CSW_NUM_STREAMS-1:0]        out_valid,
    output logic [CSW_NUM_STREAMS*DATA_W-1:0] out_data,
    input  logic [CSW_NUM_STREAMS-1:0]        out_ready,
    output logic [CSW_IDX_W-1:0]              dbg_active,
    output logic                              dbg_busy,
    output logic [CSW_NUM_STREAMS-1:0]        dbg_blocked
);
    localparam int NS = CSW_NUM_STREAMS;

    logic [DATA_W-1:0] in_head   [NS];
    logic [DATA_W-1:0] st_q      [NS];
    logic [NS-1:0]     in_full;
    logic [NS-1:0]     in_empty;
    logic [NS-1:0]     out_full;
    logic [NS-1:0]     out_empty;
    logic [NS-1:0]     served;
    logic [NS-1:0]     runnable;
    logic [DATA_W-1:0] sel_tok;
    logic [DATA_W-1:0] sel_st;
    logic [DATA_W-1:0] result;
    csw_grant_t        grant;

    // Per-stream queues and state banks; nothing is shared.
    for (genvar i = 0; i < NS; i++) begin : g_stream
        csw_fifo #(
            .WIDTH (DATA_W),
            .DEPTH (FIFO_DEPTH)
        ) u_in_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i]),
            .din   (in_data[i*DATA_W +: DATA_W]),
            .pop   (served[i]),
            .dout  (in_head[i]),
            .full  (in_full[i]),
            .empty (in_empty[i])
        );

        csw_fifo #(
            .WIDTH (DATA_W),
            .DEPTH (FIFO_DEPTH)
        ) u_out_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (served[i]),
            .din   (result),
            .pop   (out_ready[i]),
            .dout  (out_data[i*DATA_W +: DATA_W]),
            .full  (out_full[i]),
            .empty (out_empty[i])
        );

        csw_state_bank #(
            .WIDTH (DATA_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (served[i]),
            .d     (result),
            .q     (st_q[i])
        );

        // Runnability and the one-hot service strobe for this stream.
        always_comb begin
            runnable[i] = !in_empty[i] && !out_full[i];
            served[i]   = grant.busy && (grant.idx == CSW_IDX_W'(i));
        end
    end

    csw_rr_sched u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .runnable (runnable),
        .grant    (grant)
    );

    // Route the granted stream's token and state into the shared datapath.
    always_comb begin
        sel_tok = in_head[grant.idx];
        sel_st  = st_q[grant.idx];
    end

    csw_token_unit #(
        .WIDTH (DATA_W)
    ) u_dp (
        .acc (sel_st),
        .tok (sel_tok),
        .nxt (result)
    );

    // Port-facing status and debug view.
    always_comb begin
        in_ready    = ~in_full;
        out_valid   = ~out_empty;
        dbg_active  = grant.idx;
        dbg_busy    = grant.busy;
        dbg_blocked = ~runnable;
    end

endmodule

// File: rtl/stream_ctx_switch_checker.sv
// Protocol and scheduling properties of stream_ctx_switch, observed at its ports.
// Arms two cycles after reset release so that no $past reaches before reset.
module stream_ctx_switch_checker
    import csw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [CSW_NUM_STREAMS-1:0]        in_valid,
    input logic [CSW_NUM_STREAMS-1:0]        in_ready,
    input logic [CSW_NUM_STREAMS-1:0]        out_valid,
    input logic [CSW_NUM_STREAMS*DATA_W-1:0] out_data,
    input logic [CSW_NUM_STREAMS-1:0]        out_ready,
    input logic [CSW_IDX_W-1:0]              dbg_active,
    input logic                              dbg_busy,
    input logic [CSW_NUM_STREAMS-1:0]        dbg_blocked
);
    logic [1:0] age;
    logic       armed;

    // Count cycles since reset release up to two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end
    assign armed = (age == 2'd2);

    AST_GRANT_RUNNABLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        dbg_busy |-> !dbg_blocked[dbg_active]); // R6

    AST_NO_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (dbg_blocked != '1) |-> dbg_busy); // R5

    AST_IDLE_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (dbg_blocked == '1) |-> !dbg_busy); // R7

    AST_RR_REPEAT_ONLY_ALONE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (dbg_busy && $past(dbg_busy) && dbg_active == $past(dbg_active))
            |-> ($countones(~dbg_blocked) == 1)); // R4

    for (genvar i = 0; i < CSW_NUM_STREAMS; i++) begin : g_lane
        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            (out_valid[i] && !out_ready[i])
                |=> (out_valid[i] && $stable(out_data[i*DATA_W +: DATA_W]))); // R2

        AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            (!in_ready[i] && !(dbg_busy && dbg_active == CSW_IDX_W'(i)))
                |=> !in_ready[i]); // R9

        AST_INPUT_USED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            (dbg_busy && dbg_active == CSW_IDX_W'(i) && !in_valid[i])
                |=> in_ready[i]); // R9
    end

endmodule

bind stream_ctx_switch stream_ctx_switch_checker #(
    .DATA_W (DATA_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .dbg_active  (dbg_active),
    .dbg_busy    (dbg_busy),
    .dbg_blocked (dbg_blocked)
);

// File: tb/stream_ctx_switch_bench.sv
// Self-checking bench: a behavioural queue model is stepped every cycle and
// every port is compared at the falling edge.
module stream_ctx_switch_bench;
    localparam int NS    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   in_valid = '0;
    logic [NS*DW-1:0] in_data = '0;
    logic [NS-1:0]   in_ready;
    logic [NS-1:0]   out_valid;
    logic [NS*DW-1:0] out_data;
    logic [NS-1:0]   out_ready = '0;
    logic [1:0]      dbg_active;
    logic            dbg_busy;
    logic [NS-1:0]   dbg_blocked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int inq  [NS][$];
    int outq [NS][$];
    int st   [NS];
    int last_srv;

    always #10 clk = ~clk;

    stream_ctx_switch #(
        .DATA_W     (DW),
        .FIFO_DEPTH (DEPTH)
    ) u_stream_ctx_switch (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_ready   (out_ready),
        .dbg_active  (dbg_active),
        .dbg_busy    (dbg_busy),
        .dbg_blocked (dbg_blocked)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int pick();
        for (int k = 1; k <= NS; k++) begin
            int c;
            c = (last_srv + k) % NS;
            if (inq[c].size() > 0 && outq[c].size() < DEPTH) return c;
        end
        return -1;
    endfunction

    // Compare all ports with the model; called at the falling edge.
    task automatic compare(input string sum_req);
        int g;
        g = pick();
        for (int i = 0; i < NS; i++) begin
            bit run_i;
            run_i = inq[i].size() > 0 && outq[i].size() < DEPTH;
            chk(in_ready[i] == (inq[i].size() < DEPTH), "R9", "in_ready",
                int'(in_ready[i]), int'(inq[i].size() < DEPTH));
            chk(out_valid[i] == (outq[i].size() > 0), "R2", "out_valid",
                int'(out_valid[i]), int'(outq[i].size() > 0));
            if (outq[i].size() > 0)
                chk(int'(out_data[i*DW +: DW]) == outq[i][0], sum_req, "out_data",
                    int'(out_data[i*DW +: DW]), outq[i][0]);
            chk(dbg_blocked[i] == !run_i, "R6", "dbg_blocked",
                int'(dbg_blocked[i]), int'(!run_i));
        end
        chk(dbg_busy == (g >= 0), (g >= 0) ? "R5" : "R7", "dbg_busy",
            int'(dbg_busy), int'(g >= 0));
        if (g >= 0 && dbg_busy)
            chk(int'(dbg_active) == g, "R4", "dbg_active R10", int'(dbg_active), g);
    endtask

    // Advance the model by one clock using the inputs just driven.
    task automatic step_model();
        int g;
        bit acc [NS];
        g = pick();
        for (int i = 0; i < NS; i++) acc[i] = in_valid[i] && (inq[i].size() < DEPTH);
        for (int i = 0; i < NS; i++)
            if (out_ready[i] && outq[i].size() > 0) void'(outq[i].pop_front());
        if (g >= 0) begin
            int x;
            x = inq[g].pop_front();
            st[g] = (st[g] + x) & 255;
            outq[g].push_back(st[g]);
            last_srv = g;
        end
        for (int i = 0; i < NS; i++)
            if (acc[i]) inq[i].push_back(int'(in_data[i*DW +: DW]));
    endtask

    task automatic run_phase(input int cycles, input int p_in, input int p_out,
                             input logic [NS-1:0] out_mask, input string sum_req);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare(sum_req);
            for (int i = 0; i < NS; i++) begin
                in_valid[i]          = ($urandom_range(99) < p_in);
                in_data[i*DW +: DW]  = DW'($urandom_range(255));
                out_ready[i]         = out_mask[i] && ($urandom_range(99) < p_out);
            end
            step_model();
        end
    endtask

    initial begin
        void'($urandom(7));
        for (int i = 0; i < NS; i++) st[i] = 0;
        last_srv = NS - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while reset held.
        chk(in_ready == '1, "R1", "in_ready", int'(in_ready), 15);
        chk(out_valid == '0, "R1", "out_valid", int'(out_valid), 0);
        chk(dbg_busy == 1'b0, "R1", "dbg_busy", int'(dbg_busy), 0);
        chk(dbg_blocked == '1, "R1", "dbg_blocked", int'(dbg_blocked), 15);
        rst_n = 1'b1;
        // R3: dense mixed traffic, running sums compared.
        run_phase(1000, 70, 70, 4'b1111, "R3");
        // R7: outputs closed, every queue fills, then all streams idle.
        run_phase(300, 90, 0, 4'b0000, "R3");
        // R8: stream 0 frozen on a full output while others run, then released.
        run_phase(400, 80, 80, 4'b1110, "R8");
        run_phase(400, 60, 70, 4'b1111, "R8");
        // R7: no input, drain and idle.
        run_phase(300, 0, 90, 4'b1111, "R3");
        // R4: sparse traffic exercises the rotation across gaps.
        run_phase(600, 15, 90, 4'b1111, "R3");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule